// File: doc/BRIEF.md
# Truth-Table Programmed Ripple ALU

This block is an n-bit combinational arithmetic and logic unit built as a row of identical one-bit stages. No opcode decoder exists. Each stage is steered by three 4-bit truth-table codes. The pair code picks any two-input function of the operand bits. The merge code combines that function's output with the link signal that enters the stage, and the result bit comes from this combination. The link code chooses which terms drive the stage's outgoing link. Additions, subtractions, increments, negation, equality tests, bitwise logic, transfers and single-bit shifts all come from choices of these three codes, one direction bit and the value fed into the end of the chain.

The link between stages is a plain ripple, and its direction can be reversed. With the direction bit low, the link enters at bit 0, travels toward the top bit, and leaves from bit W-1. With the direction bit high, it enters at the top bit and leaves from bit 0. The link is not always a full-adder carry: a shift uses it to carry an operand bit and an equality test uses it to carry a match flag. For this reason the chain cannot be replaced by a lookahead network.

The block has no clock and no state, so a result is valid as soon as the inputs settle. Data and control pins are plain levels. There is no handshake, because nothing is held from one operation to the next.

Top module: `palu_core`

## Requirements
- R1: For each bit k, the pair output is pair_tt[{op_a[k], op_b[k]}], so pair_tt bit j gives the output for index j, with op_a as the high index bit. Examples: 6 gives XOR, 9 gives XNOR, 8 gives AND, 3 gives NOT A and 10 passes B.
- R2: Result bit k is merge_tt[{link into bit k, pair output k}], with the incoming link as the high index bit. Examples: 6 gives XOR of the two, 10 passes the pair output, 12 passes the incoming link and 8 gives their AND.
- R3: With reverse=0, link_in enters bit 0, each bit feeds bit k+1, and link_out is the link leaving bit W-1. With reverse=1, link_in enters bit W-1, each bit feeds bit k-1, and link_out is the link leaving bit 0.
- R4: The link leaving a bit is the OR of the terms enabled in link_sel. Bit 0 enables (incoming link AND pair output), bit 1 enables (op_a AND NOT pair output), bit 2 enables op_a, and bit 3 enables op_b. When link_sel=0, link_out is 0 whatever the other inputs are.
- R5: Addition uses pair 6, merge 6, link 3, reverse 0 and link_in 0. It gives {link_out, result} = op_a + op_b.
- R6: Subtraction uses pair 9, merge 6, link 3, reverse 0 and link_in 1. It gives result = op_a - op_b modulo 2^W and link_out = (op_a >= op_b) as unsigned values.
- R7: Increment of B uses pair 10, merge 6, link 1, reverse 0 and link_in 1. It gives result = op_b + 1 modulo 2^W and link_out = 1 exactly when op_b is all ones.
- R8: Negation of A uses pair 3, merge 6, link 1, reverse 0 and link_in 1. It gives the two's complement of op_a, with link_out = 1 exactly when op_a is 0.
- R9: The equality test uses pair 9, merge 8, link 1, reverse 0 and link_in 1. Result bit k is 1 when bits 0..k of op_a and op_b all match, and link_out = (op_a == op_b).
- R10: Logic operations use merge 10, link 0 and reverse 1. They give result = the bitwise pair function and link_out = 0.
- R11: Shift A left uses pair 0, merge 12, link 4 and reverse 0. It gives result = {op_a[W-2:0], link_in} and link_out = op_a[W-1].
- R12: Shift B right uses pair 0, merge 12, link 8 and reverse 1. It gives result = {link_in, op_b[W-1:1]} and link_out = op_b[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| pair_tt | input | 4 | Truth table of the per-bit function of op_a and op_b |
| merge_tt | input | 4 | Truth table combining the incoming link and the pair output into the result bit |
| link_sel | input | 4 | Enables for the terms ORed into each bit's outgoing link |
| reverse | input | 1 | 0: link ripples from bit 0 upward; 1: from bit W-1 downward |
| link_in | input | 1 | Link value fed into the entry end of the chain |
| result | output | W | Result word |
| link_out | output | 1 | Link leaving the exit end of the chain |

## Verification
The bench aims at chain lengths that span the whole word. Examples are an increment of an all-ones value, subtraction with equal operands, negation of zero, and equality that fails only in the top bit. A stage with a wrong generate or propagate term shows up here as a wrong carry-out or wrong high bits. The shifts are run in both directions with each fill value, so a chain wired the wrong way round or an exit taken from the wrong end puts the fill or the outgoing bit at the wrong end of the word. Logic operations are driven with operands that would produce carries, which exposes a link that leaks through when link_sel is zero. A scan over every pair and merge code with the link disabled catches a truth table indexed with its inputs swapped.

// File: rtl/palu_pkg.sv
package palu_pkg;

  typedef logic [3:0] tt4_t;

  // Positions of the link-term enables inside link_sel
  localparam int LNK_PROP = 0;  // incoming link AND pair output
  localparam int LNK_GEN  = 1;  // op_a AND NOT pair output
  localparam int LNK_FWDA = 2;  // forward op_a bit
  localparam int LNK_FWDB = 3;  // forward op_b bit

  // Look up a 2-input truth table, hi is the high index bit
  function automatic logic tt_pick(input tt4_t tt, input logic hi, input logic lo);
    return tt[{hi, lo}];
  endfunction

  // Outgoing link of one stage
  function automatic logic link_next(input tt4_t sel, input logic lin,
                                     input logic pe, input logic a, input logic b);
    logic [3:0] terms;
    terms[LNK_PROP] = lin & pe;
    terms[LNK_GEN]  = a & ~pe;
    terms[LNK_FWDA] = a;
    terms[LNK_FWDB] = b;
    return |(sel & terms);
  endfunction

endpackage

// File: rtl/palu_pairfn.sv
module palu_pairfn #(
  parameter int W = 8
) (
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  palu_pkg::tt4_t    pair_tt,
  output logic [W-1:0]      pair_o
);
  import palu_pkg::*;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign pair_o[k] = tt_pick(pair_tt, op_a[k], op_b[k]);
  end

endmodule

// File: rtl/palu_ripple.sv
module palu_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [W-1:0]      pair_v,
  input  palu_pkg::tt4_t    merge_tt,
  input  palu_pkg::tt4_t    link_sel,
  input  logic              reverse,
  input  logic              link_in,
  output logic [W-1:0]      result,
  output logic              link_out
);
  import palu_pkg::*;

  localparam int IW = (W > 1) ? $clog2(W) : 1;

  // One walk along the chain; the stage order follows the direction bit
  always_comb begin
    logic          lnk;
    logic [W-1:0]  res_v;
    logic [IW-1:0] k;
    lnk   = link_in;
    res_v = '0;
    for (int s = 0; s < W; s++) begin
      k        = reverse ? IW'(W - 1 - s) : IW'(s);
      res_v[k] = tt_pick(merge_tt, lnk, pair_v[k]);
      lnk      = link_next(link_sel, lnk, pair_v[k], op_a[k], op_b[k]);
    end
    result   = res_v;
    link_out = lnk;
  end

  // With every link term disabled no link may leave the chain
  always_comb begin
    if (link_sel == 4'd0)
      assert_link_quiet_R4: assert (link_out == 1'b0)
        else $error("link_out active with link_sel zero");
  end

endmodule

// File: rtl/palu_core.sv
module palu_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   pair_tt,
  input  logic [3:0]   merge_tt,
  input  logic [3:0]   link_sel,
  input  logic         reverse,
  input  logic         link_in,
  output logic [W-1:0] result,
  output logic         link_out
);

  logic [W-1:0] pair_w;

  palu_pairfn #(.W(W)) u_pair (
    .op_a    (op_a),
    .op_b    (op_b),
    .pair_tt (pair_tt),
    .pair_o  (pair_w)
  );

  palu_ripple #(.W(W)) u_chain (
    .op_a     (op_a),
    .op_b     (op_b),
    .pair_v   (pair_w),
    .merge_tt (merge_tt),
    .link_sel (link_sel),
    .reverse  (reverse),
    .link_in  (link_in),
    .result   (result),
    .link_out (link_out)
  );

  // Arithmetic and shift code points checked against plain word arithmetic
  logic [W:0]   sum_ref;
  logic [W-1:0] logic_ref;
  always_comb begin
    sum_ref   = {1'b0, op_a} + {1'b0, op_b};
    logic_ref = ({W{pair_tt[3]}} &  op_a &  op_b) | ({W{pair_tt[2]}} &  op_a & ~op_b) |
                ({W{pair_tt[1]}} & ~op_a &  op_b) | ({W{pair_tt[0]}} & ~op_a & ~op_b);

    if (pair_tt == 4'd6 && merge_tt == 4'd6 && link_sel == 4'd3 && !reverse && !link_in)
      assert_add_sum_R5: assert ({link_out, result} == sum_ref)
        else $error("add mismatch");

    if (pair_tt == 4'd9 && merge_tt == 4'd6 && link_sel == 4'd3 && !reverse && link_in)
      assert_sub_diff_R6: assert (result == W'(op_a - op_b) && link_out == (op_a >= op_b))
        else $error("sub mismatch");

    if (merge_tt == 4'd10 && link_sel == 4'd0 && reverse)
      assert_logic_word_R10: assert (result == logic_ref && !link_out)
        else $error("logic mismatch");

    if (pair_tt == 4'd0 && merge_tt == 4'd12 && link_sel == 4'd4 && !reverse)
      assert_shift_left_R11: assert (result == {op_a[W-2:0], link_in} && link_out == op_a[W-1])
        else $error("shift left mismatch");

    if (pair_tt == 4'd0 && merge_tt == 4'd12 && link_sel == 4'd8 && reverse)
      assert_shift_right_R12: assert (result == {link_in, op_b[W-1:1]} && link_out == op_b[0])
        else $error("shift right mismatch");
  end

endmodule

// File: tb/palu_core_tb.sv
module palu_core_tb;

  localparam int W = 8;
  localparam int N = 40;

  logic         clk = 1'b0;
  logic [W-1:0] op_a, op_b;
  logic [3:0]   pair_tt, merge_tt, link_sel;
  logic         reverse, link_in;
  logic [W-1:0] result;
  logic         link_out;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  palu_core #(.W(W)) u_dut (
    .op_a(op_a), .op_b(op_b), .pair_tt(pair_tt), .merge_tt(merge_tt),
    .link_sel(link_sel), .reverse(reverse), .link_in(link_in),
    .result(result), .link_out(link_out)
  );

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] pt,
                       input logic [3:0] mt, input logic [3:0] ls, input logic rv, input logic li);
    @(negedge clk);
    op_a = a; op_b = b; pair_tt = pt; merge_tt = mt; link_sel = ls; reverse = rv; link_in = li;
    #2;
  endtask

  task automatic t_idle;
    drive('0, '0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0);
    check("R4 all-zero inputs", {link_out, result}, '0);
  endtask

  task automatic t_add;
    logic [W-1:0] a, b;
    for (int i = 0; i < N + 2; i++) begin
      a = W'($urandom); b = W'($urandom);
      if (i == N) begin a = '1; b = 8'd1; end
      if (i == N + 1) begin a = '1; b = '1; end
      drive(a, b, 4'd6, 4'd6, 4'd3, 1'b0, 1'b0);
      check("R5 add", {link_out, result}, {1'b0, a} + {1'b0, b});
    end
  endtask

  task automatic t_sub;
    logic [W-1:0] a, b;
    for (int i = 0; i < N + 2; i++) begin
      a = W'($urandom); b = W'($urandom);
      if (i == N) b = a;
      if (i == N + 1) begin a = '0; b = 8'd1; end
      drive(a, b, 4'd9, 4'd6, 4'd3, 1'b0, 1'b1);
      check("R6 sub", {link_out, result}, {(a >= b) ? 1'b1 : 1'b0, W'(a - b)});
    end
  endtask

  task automatic t_inc;
    logic [W-1:0] b;
    for (int i = 0; i < N + 1; i++) begin
      b = (i == N) ? '1 : W'($urandom);
      drive(W'($urandom), b, 4'd10, 4'd6, 4'd1, 1'b0, 1'b1);
      check("R7 increment", {link_out, result}, {(b == '1) ? 1'b1 : 1'b0, W'(b + 1)});
    end
  endtask

  task automatic t_neg;
    logic [W-1:0] a;
    for (int i = 0; i < N + 1; i++) begin
      a = (i == N) ? '0 : W'($urandom);
      drive(a, W'($urandom), 4'd3, 4'd6, 4'd1, 1'b0, 1'b1);
      check("R8 negate", {link_out, result}, {(a == '0) ? 1'b1 : 1'b0, W'(~a + 1)});
    end
  endtask

  task automatic t_eq;
    logic [W-1:0] a, b, ex;
    logic run;
    for (int i = 0; i < N; i++) begin
      a = W'($urandom);
      case (i % 3)
        0: b = a;
        1: b = a ^ 8'h80;
        default: b = W'($urandom);
      endcase
      run = 1'b1;
      for (int k = 0; k < W; k++) begin
        run = run & (a[k] == b[k]);
        ex[k] = run;
      end
      drive(a, b, 4'd9, 4'd8, 4'd1, 1'b0, 1'b1);
      check("R9 equality", {link_out, result}, {(a == b) ? 1'b1 : 1'b0, ex});
    end
  endtask

  task automatic t_logic;
    logic [W-1:0] a, b;
    logic [3:0] codes [5] = '{4'd6, 4'd9, 4'd8, 4'd3, 4'd10};
    logic [W-1:0] ex;
    for (int c = 0; c < 5; c++) begin
      for (int i = 0; i < 8; i++) begin
        a = W'($urandom); b = (i == 0) ? a : W'($urandom);
        case (codes[c])
          4'd6:    ex = a ^ b;
          4'd9:    ex = ~(a ^ b);
          4'd8:    ex = a & b;
          4'd3:    ex = ~a;
          default: ex = b;
        endcase
        drive(a, b, codes[c], 4'd10, 4'd0, 1'b1, i[0]);
        check("R10 logic", {link_out, result}, {1'b0, ex});
      end
    end
  endtask

  task automatic t_no_link;
    logic [W-1:0] a, b;
    for (int i = 0; i < 16; i++) begin
      a = W'($urandom) | 8'h81; b = W'($urandom) | 8'h81;
      drive(a, b, 4'(i), 4'd12, 4'd0, i[1], 1'b1);
      check("R4 link disabled", {W'(0), link_out}, '0);
    end
  endtask

  task automatic t_shl;
    logic [W-1:0] a;
    for (int i = 0; i < N; i++) begin
      a = W'($urandom);
      drive(a, W'($urandom), 4'd0, 4'd12, 4'd4, 1'b0, i[0]);
      check("R11 shift left", {link_out, result}, {a[W-1], a[W-2:0], i[0]});
    end
  endtask

  task automatic t_shr;
    logic [W-1:0] b;
    for (int i = 0; i < N; i++) begin
      b = W'($urandom);
      drive(W'($urandom), b, 4'd0, 4'd12, 4'd8, 1'b1, i[0]);
      check("R12 shift right", {link_out, result}, {b[0], i[0], b[W-1:1]});
    end
  endtask

  // R1 and R2: every pair and merge code with the link carrying only link_in into bit 0 (R3)
  task automatic t_tables;
    logic [W-1:0] a, b, ex;
    logic e;
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        a = W'($urandom); b = W'($urandom);
        for (int k = 0; k < W; k++) begin
          e = p[{a[k], b[k]}];
          ex[k] = (k == 0) ? m[{1'b1, e}] : m[{1'b0, e}];
        end
        drive(a, b, 4'(p), 4'(m), 4'd0, 1'b0, 1'b1);
        check("R1 R2 R3 table scan", {1'b0, result}, {1'b0, ex});
      end
    end
  endtask

  initial begin
    fork
      begin
        t_idle;
        t_add;
        t_sub;
        t_inc;
        t_neg;
        t_eq;
        t_logic;
        t_no_link;
        t_shl;
        t_shr;
        t_tables;
      end
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule